// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a circular queue of 16-byte transmit descriptors kept in host memory. Software sets the ring's start address, its size in bytes, a tail index and a control word through a narrow register write port. Slots from the head index up to, but not including, the tail index belong to the engine. Slots from tail back round to head belong to software. The engine reads each owned slot as four 32-bit words over a request/acknowledge memory port and splits out the buffer pointer, byte count, command byte and checksum and tag fields. It then offers the buffer to a downstream packet mover through a valid/ready hand-off.

Once a slot has been handled, the engine may write the slot's last word back with the done flag set. It does this when the command byte asks for a status report, or always when the control word's granularity bit is set. Only after that write finishes does it move the head index one slot on, wrapping to zero at the end of the ring. Slots with a zero byte count, and slots that ask for the extended format, are not offered downstream. They are still completed, so that ownership returns to software.

Top module: `txq_ring_engine`

## Requirements
- R1: While reset is held, and until work is posted, `ring_head` is 0 and `mem_req` and `buf_valid` are low.
- R2: A write with `reg_we` high stores `reg_wdata` according to `reg_addr`. Code 0 sets ring start bits 31:0, code 1 sets start bits 63:32, code 2 sets the ring size in bytes, code 3 sets the tail index, and code 4 sets control (bit 0 enable, bit 1 granularity).
- R3: A slot is fetched as four reads at start + head*16 + 0, 4, 8 and 12, in that order. Each request is held with a steady address until `mem_ack`.
- R4: From the fetched words, the buffer address is word1:word0, the byte count is word2[15:0], the checksum offset is word2[23:16], the command is word2[31:24], the checksum start is word3[15:8] and the tag field is word3[31:16]. These are offered with `buf_valid` and held until `buf_ready`.
- R5: When command bit 3 (report status) is set, the engine writes address start + head*16 + 12 with word3 once the slot is done. In that write bit 0 (done) is set and every other bit is unchanged.
- R6: With control bit 1 set, every slot is written back as in R5, whatever its command bit 3.
- R7: With command bit 3 and control bit 1 both clear, no write is made and the slot in memory is left as it was.
- R8: A slot with a byte count of 0 is not offered downstream, but it is still completed: written back under R5/R6, then head advances.
- R9: A slot with command bit 5 (extended format) set is treated like R8, since only the legacy format is accepted.
- R10: Head moves to the next slot only after any write-back has been acknowledged. It wraps from (size/16 - 1) to 0.
- R11: A tail write while control bit 0 is low is stored, but no fetch starts until bit 0 is set.
- R12: While the ring size is below 128 bytes, no fetch starts.
- R13: When head equals tail the engine stays idle and makes no memory requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select code |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory access completed |
| buf_valid | output | 1 | Buffer request valid |
| buf_ready | input | 1 | Packet mover accepts request |
| buf_addr | output | 64 | Buffer address |
| buf_len | output | 16 | Buffer byte count |
| buf_cmd | output | 8 | Command byte |
| buf_cso | output | 8 | Checksum offset |
| buf_css | output | 8 | Checksum start |
| buf_special | output | 16 | Tag field |
| ring_head | output | IDX_W | Current head index |

## Verification
The bench builds the engine with its default parameters: 16-bit indices, a 20-bit ring size and a 128-byte minimum. It programs the smallest legal ring of eight slots, so one pass of tail past the end brings head through the wrap from slot 7 to slot 0 within a few dozen cycles. It then writes a 64-byte size, which falls below the 128-byte minimum, to reach the short-ring guard. The scoreboard lines every fetch address, hand-off and write-back up against the slots posted, with the downstream ready both held high and throttled.

// File: rtl/txq_pkg.sv
package txq_pkg;

  localparam int SLOT_BYTES = 16;
  localparam int WORDS_PER_SLOT = 4;

  localparam logic [2:0] RSEL_BASE_LO = 3'd0;
  localparam logic [2:0] RSEL_BASE_HI = 3'd1;
  localparam logic [2:0] RSEL_SIZE    = 3'd2;
  localparam logic [2:0] RSEL_TAIL    = 3'd3;
  localparam logic [2:0] RSEL_CTRL    = 3'd4;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_GRAN = 1;

  localparam int CMD_EOP  = 0;
  localparam int CMD_RS   = 3;
  localparam int CMD_DEXT = 5;

  localparam int STS_DONE = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECIDE,
    ST_HAND,
    ST_WB,
    ST_ADV
  } walk_st_e;

endpackage

// File: rtl/txq_rst_sync.sv
module txq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_nq
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_nq = sync_q[1];

endmodule

// File: rtl/txq_regs.sv
module txq_regs
  import txq_pkg::*;
#(
  parameter int IDX_W = 16,
  parameter int LEN_W = 20
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             we,
  input  logic [2:0]       sel,
  input  logic [31:0]      wdata,
  output logic [63:0]      base,
  output logic [LEN_W-1:0] size_bytes,
  output logic [IDX_W-1:0] tail,
  output logic             en,
  output logic             gran
);

  logic [63:0]      base_d;
  logic [LEN_W-1:0] size_d;
  logic [IDX_W-1:0] tail_d;
  logic             en_d, gran_d;
  logic             unused_wbits;

  assign unused_wbits = ^wdata;

  always_comb begin
    base_d = base;
    size_d = size_bytes;
    tail_d = tail;
    en_d   = en;
    gran_d = gran;
    if (we) begin
      case (sel)
        RSEL_BASE_LO: base_d[31:0]  = wdata;
        RSEL_BASE_HI: base_d[63:32] = wdata;
        RSEL_SIZE:    size_d = wdata[LEN_W-1:0];
        RSEL_TAIL:    tail_d = wdata[IDX_W-1:0];
        RSEL_CTRL: begin
          en_d   = wdata[CTRL_EN];
          gran_d = wdata[CTRL_GRAN];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      base       <= '0;
      size_bytes <= '0;
      tail       <= '0;
      en         <= 1'b0;
      gran       <= 1'b0;
    end else begin
      base       <= base_d;
      size_bytes <= size_d;
      tail       <= tail_d;
      en         <= en_d;
      gran       <= gran_d;
    end
  end

  // R2: tail register follows a write to its code on the next cycle
  assert_tail_write_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (we && sel == RSEL_TAIL) |=> (tail == $past(wdata[IDX_W-1:0])));

endmodule

// File: rtl/txq_desc_dec.sv
module txq_desc_dec
  import txq_pkg::*;
(
  input  logic [127:0] words,
  input  logic         gran,
  output logic [63:0]  f_addr,
  output logic [15:0]  f_len,
  output logic [7:0]   f_cso,
  output logic [7:0]   f_cmd,
  output logic [7:0]   f_css,
  output logic [15:0]  f_special,
  output logic         skip,
  output logic         want_wb,
  output logic [31:0]  wb_word
);

  logic [7:0] f_sts;

  always_comb begin
    f_addr    = words[63:0];
    f_len     = words[79:64];
    f_cso     = words[87:80];
    f_cmd     = words[95:88];
    f_sts     = words[103:96];
    f_css     = words[111:104];
    f_special = words[127:112];
    skip      = (f_len == 16'd0) || f_cmd[CMD_DEXT];
    want_wb   = f_cmd[CMD_RS] || gran;
    wb_word   = {f_special, f_css, f_sts | (8'd1 << STS_DONE)};
  end

endmodule

// File: rtl/txq_walker.sv
module txq_walker
  import txq_pkg::*;
#(
  parameter int IDX_W          = 16,
  parameter int LEN_W          = 20,
  parameter int MIN_RING_BYTES = 128
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [63:0]      base,
  input  logic [LEN_W-1:0] size_bytes,
  input  logic [IDX_W-1:0] tail,
  input  logic             en,
  input  logic             desc_skip,
  input  logic             desc_wb,
  input  logic [31:0]      wb_word,
  output logic             mem_req,
  output logic             mem_we,
  output logic [63:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack,
  output logic             buf_valid,
  input  logic             buf_ready,
  output logic [127:0]     words_q,
  output logic [IDX_W-1:0] head_q
);

  localparam int CNT_W   = LEN_W - 4;
  localparam int WCNT_W  = $clog2(WORDS_PER_SLOT);
  localparam int SHIFT_S = $clog2(SLOT_BYTES);

  walk_st_e          state_q, state_d;
  logic [WCNT_W-1:0] wcnt_q, wcnt_d;
  logic [IDX_W-1:0]  head_d, head_next;
  logic [127:0]      words_d;
  logic [CNT_W-1:0]  ring_cnt;
  logic              ring_ok, ring_busy, at_last;
  logic [63:0]       slot_addr;
  logic [WCNT_W-1:0] word_sel;

  assign ring_cnt  = size_bytes[LEN_W-1:4];
  assign ring_ok   = 32'(size_bytes) >= 32'(MIN_RING_BYTES);
  assign ring_busy = (head_q != tail);
  assign at_last   = (32'(head_q) + 32'd1) >= 32'(ring_cnt);
  assign head_next = at_last ? '0 : head_q + IDX_W'(1);

  assign slot_addr = base + (64'(head_q) << SHIFT_S);
  assign word_sel  = (state_q == ST_WB) ? WCNT_W'(WORDS_PER_SLOT - 1) : wcnt_q;
  assign mem_addr  = slot_addr + {{(62 - WCNT_W){1'b0}}, word_sel, 2'b00};
  assign mem_wdata = wb_word;

  always_comb begin
    state_d   = state_q;
    wcnt_d    = wcnt_q;
    head_d    = head_q;
    words_d   = words_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    buf_valid = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (en && ring_ok && ring_busy) begin
          state_d = ST_FETCH;
          wcnt_d  = '0;
        end
      end
      ST_FETCH: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          words_d[{wcnt_q, 5'b00000} +: 32] = mem_rdata;
          if (wcnt_q == WCNT_W'(WORDS_PER_SLOT - 1)) state_d = ST_DECIDE;
          else                                       wcnt_d  = wcnt_q + WCNT_W'(1);
        end
      end
      ST_DECIDE: begin
        if (desc_skip) state_d = desc_wb ? ST_WB : ST_ADV;
        else           state_d = ST_HAND;
      end
      ST_HAND: begin
        buf_valid = 1'b1;
        if (buf_ready) state_d = desc_wb ? ST_WB : ST_ADV;
      end
      ST_WB: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) state_d = ST_ADV;
      end
      ST_ADV: begin
        head_d  = head_next;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      head_q  <= '0;
      words_q <= '0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      head_q  <= head_d;
      words_q <= words_d;
    end
  end

  // R3: a pending memory request keeps its address and direction
  assert_mem_hold_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R4: an offered buffer stays offered with the same contents
  assert_buf_hold_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (buf_valid && !buf_ready) |=> (buf_valid && $stable(words_q)));

  // R7: writes only for slots that asked, or when every slot is written back
  assert_wb_gated_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req && mem_we) |-> desc_wb);

  // R10: head only steps by one or wraps to zero
  assert_head_step_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(head_q) |-> (head_q == '0 || head_q == $past(head_q) + IDX_W'(1)));

  // R11: a fetch only begins after enable was seen
  assert_fetch_needs_en_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_FETCH && $past(state_q) == ST_IDLE) |-> $past(en));

  // R12: a fetch only begins on a ring of legal size
  assert_short_ring_idle_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_FETCH && $past(state_q) == ST_IDLE) |-> $past(ring_ok));

  // R13: an empty ring issues no memory traffic
  assert_empty_idle_R13: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_IDLE && !ring_busy) |=> !mem_req);

endmodule

// File: rtl/txq_ring_engine.sv
module txq_ring_engine
  import txq_pkg::*;
#(
  parameter int IDX_W          = 16,
  parameter int LEN_W          = 20,
  parameter int MIN_RING_BYTES = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [63:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack,
  output logic             buf_valid,
  input  logic             buf_ready,
  output logic [63:0]      buf_addr,
  output logic [15:0]      buf_len,
  output logic [7:0]       buf_cmd,
  output logic [7:0]       buf_cso,
  output logic [7:0]       buf_css,
  output logic [15:0]      buf_special,
  output logic [IDX_W-1:0] ring_head
);

  logic             rst_nq;
  logic [63:0]      cfg_base;
  logic [LEN_W-1:0] cfg_size;
  logic [IDX_W-1:0] cfg_tail;
  logic             cfg_en, cfg_gran;
  logic [127:0]     slot_words;
  logic             d_skip, d_wb;
  logic [31:0]      d_wb_word;

  txq_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_nq (rst_nq)
  );

  txq_regs #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_regs (
    .clk        (clk),
    .rst_ni     (rst_nq),
    .we         (reg_we),
    .sel        (reg_addr),
    .wdata      (reg_wdata),
    .base       (cfg_base),
    .size_bytes (cfg_size),
    .tail       (cfg_tail),
    .en         (cfg_en),
    .gran       (cfg_gran)
  );

  txq_desc_dec u_dec (
    .words     (slot_words),
    .gran      (cfg_gran),
    .f_addr    (buf_addr),
    .f_len     (buf_len),
    .f_cso     (buf_cso),
    .f_cmd     (buf_cmd),
    .f_css     (buf_css),
    .f_special (buf_special),
    .skip      (d_skip),
    .want_wb   (d_wb),
    .wb_word   (d_wb_word)
  );

  txq_walker #(.IDX_W(IDX_W), .LEN_W(LEN_W), .MIN_RING_BYTES(MIN_RING_BYTES)) u_walk (
    .clk        (clk),
    .rst_ni     (rst_nq),
    .base       (cfg_base),
    .size_bytes (cfg_size),
    .tail       (cfg_tail),
    .en         (cfg_en),
    .desc_skip  (d_skip),
    .desc_wb    (d_wb),
    .wb_word    (d_wb_word),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ack    (mem_ack),
    .buf_valid  (buf_valid),
    .buf_ready  (buf_ready),
    .words_q    (slot_words),
    .head_q     (ring_head)
  );

  // R8: empty buffers never reach the packet mover
  assert_no_empty_handoff_R8: assert property (@(posedge clk) disable iff (!rst_nq)
    buf_valid |-> (buf_len != 16'd0));

  // R9: extended-format slots never reach the packet mover
  assert_no_ext_handoff_R9: assert property (@(posedge clk) disable iff (!rst_nq)
    buf_valid |-> !buf_cmd[CMD_DEXT]);

  // R5: a write-back always carries the done flag
  assert_wb_done_flag_R5: assert property (@(posedge clk) disable iff (!rst_nq)
    (mem_req && mem_we) |-> mem_wdata[STS_DONE]);

endmodule

// File: tb/txq_ring_engine_tb.sv
module txq_ring_engine_tb;

  localparam int IDX_W = 16;
  localparam logic [63:0] BASE = 64'h100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        buf_valid;
  logic        buf_ready = 1'b1;
  logic [63:0] buf_addr;
  logic [15:0] buf_len;
  logic [7:0]  buf_cmd, buf_cso, buf_css;
  logic [15:0] buf_special;
  logic [IDX_W-1:0] ring_head;

  always #4 clk = ~clk;

  txq_ring_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .buf_valid(buf_valid), .buf_ready(buf_ready),
    .buf_addr(buf_addr), .buf_len(buf_len), .buf_cmd(buf_cmd), .buf_cso(buf_cso),
    .buf_css(buf_css), .buf_special(buf_special), .ring_head(ring_head)
  );

  int checks = 0;
  int fails = 0;
  int req_cycles = 0;
  int cyc = 0;
  logic stall = 1'b0;

  logic [31:0] mem [0:511];
  logic        poke_en = 1'b0;
  logic [8:0]  poke_idx = '0;
  logic [31:0] poke_data = '0;

  typedef struct packed { logic [63:0] addr; logic [31:0] data; logic [15:0] idx; } wb_t;
  logic [127:0] exp_hand [$];
  logic [63:0]  exp_rd [$];
  wb_t          exp_wb [$];

  task automatic check(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: one-cycle acknowledge, bench pokes applied here too
  always @(posedge clk) begin
    cyc <= cyc + 1;
    buf_ready <= stall ? (cyc[1:0] == 2'b00) : 1'b1;
    if (poke_en) mem[poke_idx] <= poke_data;
    if (mem_req && mem_we && mem_ack) mem[mem_addr[10:2]] <= mem_wdata;
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[10:2]];
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // monitor: compare every completed transfer against the scoreboard
  always @(negedge clk) begin
    if (mem_req) req_cycles++;
    if (mem_req && !mem_we && mem_ack) begin
      if (exp_rd.size() == 0) check(1'b0, "R3 unexpected read", mem_addr, 0);
      else begin
        logic [63:0] e;
        e = exp_rd.pop_front();
        check(mem_addr == e, "R3 read address", mem_addr, e);
      end
    end
    if (mem_req && mem_we && mem_ack) begin
      if (exp_wb.size() == 0) check(1'b0, "R7 unexpected write-back", mem_addr, 0);
      else begin
        wb_t w;
        w = exp_wb.pop_front();
        check(mem_addr == w.addr && mem_wdata == w.data, "R5 write-back addr/data",
              {mem_addr, mem_wdata}, {w.addr, w.data});
        check(ring_head == w.idx, "R10 head held during write-back", ring_head, w.idx);
      end
    end
    if (buf_valid && buf_ready) begin
      logic [127:0] a;
      a = {8'h0, buf_addr, buf_len, buf_cmd, buf_cso, buf_css, buf_special};
      if (exp_hand.size() == 0) check(1'b0, "R8 unexpected hand-off", a, 0);
      else begin
        logic [127:0] e;
        e = exp_hand.pop_front();
        check(a == e, "R4 hand-off fields", a, e);
      end
    end
  end

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic poke(input logic [8:0] i, input logic [31:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_idx = i; poke_data = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  // driver: place a slot in memory and push what it should produce
  task automatic post(input int idx, input logic [15:0] len, input logic [7:0] cmd,
                      input logic [7:0] sts, input logic gran, input logic [7:0] tag);
    logic [63:0] ba, sa;
    logic [31:0] w2, w3;
    logic [7:0]  cso, css;
    logic [15:0] spc;
    ba  = 64'h0000_0012_3400_0000 + 64'(idx) * 64'h800 + 64'(tag);
    cso = 8'h10 + tag;
    css = 8'h30 + tag;
    spc = 16'hA000 + 16'(tag);
    w2  = {cmd, cso, len};
    w3  = {spc, css, sts};
    sa  = BASE + 64'(idx) * 16;
    poke(sa[10:2],     ba[31:0]);
    poke(sa[10:2] + 1, ba[63:32]);
    poke(sa[10:2] + 2, w2);
    poke(sa[10:2] + 3, w3);
    for (int k = 0; k < 4; k++) exp_rd.push_back(sa + 64'(k * 4));
    if (len != 0 && !cmd[5]) exp_hand.push_back({8'h0, ba, len, cmd, cso, css, spc});
    if (cmd[3] || gran) exp_wb.push_back('{addr: sa + 12, data: w3 | 32'h1, idx: 16'(idx)});
  endtask

  task automatic wait_head(input int target);
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (ring_head == IDX_W'(target)) break;
    end
    repeat (5) @(negedge clk);
    check(ring_head == IDX_W'(target), "R10 head after drain", ring_head, target);
    check(exp_rd.size() == 0, "R3 all reads seen", exp_rd.size(), 0);
    check(exp_hand.size() == 0, "R4 all hand-offs seen", exp_hand.size(), 0);
    check(exp_wb.size() == 0, "R5 all write-backs seen", exp_wb.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ring_head == 0 && !mem_req && !buf_valid, "R1 reset state",
          {ring_head, mem_req, buf_valid}, 0);

    reg_wr(3'd0, 32'(BASE));
    reg_wr(3'd1, 32'h0);
    reg_wr(3'd2, 32'd128);
    reg_wr(3'd4, 32'h0);

    // phase A: posted while disabled, legacy write-back rules
    post(0, 16'd60,  8'h09, 8'h00, 1'b0, 8'h01);
    post(1, 16'd0,   8'h09, 8'h04, 1'b0, 8'h02);
    post(2, 16'd100, 8'h03, 8'h00, 1'b0, 8'h03);
    req_cycles = 0;
    reg_wr(3'd3, 32'd3);
    repeat (20) @(negedge clk);
    check(req_cycles == 0, "R11 no fetch while disabled", req_cycles, 0);
    check(ring_head == 0, "R11 head unmoved while disabled", ring_head, 0);
    reg_wr(3'd4, 32'h1);
    wait_head(3);
    check(mem[(BASE[10:2] + 8) + 3] == {16'hA003, 8'h33, 8'h00}, "R7 slot left untouched",
          mem[(BASE[10:2] + 8) + 3], {16'hA003, 8'h33, 8'h00});
    check(mem[(BASE[10:2] + 4) + 3] == {16'hA002, 8'h32, 8'h05}, "R8 empty slot completed",
          mem[(BASE[10:2] + 4) + 3], {16'hA002, 8'h32, 8'h05});
    req_cycles = 0;
    repeat (20) @(negedge clk);
    check(req_cycles == 0, "R13 idle when empty", req_cycles, 0);

    // phase B: write back everything, throttled mover, wrap past slot 7
    reg_wr(3'd4, 32'h3);
    stall = 1'b1;
    post(3, 16'd40,   8'h21, 8'h00, 1'b1, 8'h04);
    post(4, 16'd64,   8'h01, 8'h00, 1'b1, 8'h05);
    post(5, 16'd1500, 8'h0B, 8'h02, 1'b1, 8'h06);
    post(6, 16'd0,    8'h00, 8'h00, 1'b1, 8'h07);
    post(7, 16'd8,    8'h41, 8'h00, 1'b1, 8'h08);
    post(0, 16'd200,  8'h01, 8'h00, 1'b1, 8'h09);
    reg_wr(3'd3, 32'd1);
    wait_head(1);
    check(mem[(BASE[10:2] + 12) + 3] == {16'hA004, 8'h34, 8'h01}, "R9 extended slot completed",
          mem[(BASE[10:2] + 12) + 3], {16'hA004, 8'h34, 8'h01});
    check(mem[(BASE[10:2] + 16) + 3] == {16'hA005, 8'h35, 8'h01}, "R6 write-back without report bit",
          mem[(BASE[10:2] + 16) + 3], {16'hA005, 8'h35, 8'h01});

    // phase C: ring below the minimum size
    reg_wr(3'd4, 32'h1);
    stall = 1'b0;
    reg_wr(3'd2, 32'd64);
    post(1, 16'd30, 8'h08, 8'h00, 1'b0, 8'h0A);
    post(2, 16'd0,  8'h00, 8'h00, 1'b0, 8'h0B);
    req_cycles = 0;
    reg_wr(3'd3, 32'd3);
    repeat (30) @(negedge clk);
    check(req_cycles == 0, "R12 no fetch on short ring", req_cycles, 0);
    check(ring_head == 1, "R12 head unmoved on short ring", ring_head, 1);
    reg_wr(3'd2, 32'd128);
    wait_head(3);
    check(mem[(BASE[10:2] + 8) + 3] == {16'hA00B, 8'h3B, 8'h00}, "R2 R7 skipped slot not written",
          mem[(BASE[10:2] + 8) + 3], {16'hA00B, 8'h3B, 8'h00});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule